// File: doc/BRIEF.md
# Multi-Channel Periodic Pulse Pattern Generator

This block drives twelve single-bit test wires, each carrying a free-running pulse train that is one bit per clock. Every wire repeats with the same eleven-cycle period. Each wire splits that period into its own high part followed by a low part, so the wires carry pulses and gaps of different lengths at the same time. The outputs feed the inputs of a time-to-digital converter under test. Because the pulses and gaps run from 2 to 9 bits, some are shorter and some longer than the converter's expected resolution of about four bits (plus or minus half a bit), and that limit can be read off from what the converter records.

A single modulo-11 phase counter sets the timing for every channel. Each channel holds a 4-bit high-length register that a write port can change. A written value is first held as pending and is only loaded at the end of a period, so a pulse train never changes part way through a period. An enable input stops the whole pattern and holds every wire low. The pattern has no fixed phase relation to any outside clock.

Top module: `pulse_pattern_gen`

## Requirements
- R1: One phase counter shared by all channels steps 0,1,…,10,0 on each enabled clock, so every output repeats with a period of exactly 11 enabled cycles.
- R2: Output bit i is high while the phase is less than channel i's active high length, and low for the rest of the period. The high run and the low run always add up to 11.
- R3: After reset the active lengths of channels 0..11 are 8,3,7,4,6,5,9,4,7,2,6,5, and the phase is 0. The first enabled cycle after reset therefore shows every output high.
- R4: While `en` is low, all twelve outputs are low.
- R5: While `en` is low, the phase does not advance. When `en` returns high, the pattern continues from the phase it was frozen at.
- R6: A write (`wrEn` high, `wrChan` = binary channel index, `wrLen` = unsigned length) goes into a pending register. It becomes active only on the clock that wraps the phase from 10 to 0, so the period already in progress does not change.
- R7: A written length of 0 is stored as 1, and a written length of 11 to 15 is stored as 10. Values 1 to 10 are stored as written.
- R8: A write made in the same cycle as a wrap is applied to the period that starts right after that wrap.
- R9: A write whose `wrChan` is 12 to 15 changes no channel.
- R10: Asserting the synchronous reset in the middle of a run restores the default lengths (this also discards any pending writes) and returns the phase to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Pattern enable. Low freezes the phase and holds all outputs low |
| wrEn | input | 1 | Length write strobe |
| wrChan | input | 4 | Channel index of the write, binary |
| wrLen | input | 4 | Requested high length, unsigned, clamped to 1..10 |
| pulseOut | output | 12 | Pattern outputs, bit i is channel i |

## Verification
Two events can fall in the same cycle: a length write and the phase wrap that loads pending lengths into the active set. The bench lets the phase reach 10 and then applies a write in exactly that cycle. It checks that the new length shapes the very next period and does not wait one period longer. Separately, writes placed in the middle of a period must leave the rest of that period unchanged. Every output is compared cycle by cycle against a model built from the requirements. In addition, the high and low run lengths of the default pattern are measured over 22 periods.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  localparam int NUM_CH = 12;
  localparam int PERIOD = 11;
  localparam int LEN_W  = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;   // pattern enabled this cycle
    logic wrap;  // phase leaves its last value this cycle
  } ppgStrobe_t;

  // Reset high length for each channel
  function automatic logic [LEN_W-1:0] defaultLen(input int ch);
    case (ch)
      0:       return LEN_W'(8);
      1:       return LEN_W'(3);
      2:       return LEN_W'(7);
      3:       return LEN_W'(4);
      4:       return LEN_W'(6);
      5:       return LEN_W'(5);
      6:       return LEN_W'(9);
      7:       return LEN_W'(4);
      8:       return LEN_W'(7);
      9:       return LEN_W'(2);
      10:      return LEN_W'(6);
      11:      return LEN_W'(5);
      default: return LEN_W'(PERIOD / 2);
    endcase
  endfunction

  // Keep a requested length inside 1..maxLen
  function automatic logic [LEN_W-1:0] clampLen(input logic [LEN_W-1:0] v,
                                                input int maxLen);
    if (v == '0)             return LEN_W'(1);
    else if (int'(v) > maxLen) return LEN_W'(maxLen);
    else                     return v;
  endfunction
endpackage

// File: rtl/ppg_ctrl.sv
module ppg_ctrl #(
  parameter int PERIOD = ppg_pkg::PERIOD,
  parameter int PH_W   = $clog2(PERIOD)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  output logic [PH_W-1:0]     phase,
  output ppg_pkg::ppgStrobe_t strobe
);
  localparam logic [PH_W-1:0] LAST_PHASE = PH_W'(PERIOD - 1);

  logic atLast;
  assign atLast = (phase == LAST_PHASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (en) begin
      phase <= atLast ? '0 : phase + PH_W'(1);
    end
  end

  always_comb begin
    strobe.run  = en;
    strobe.wrap = en && atLast;
  end
endmodule

// File: rtl/ppg_datapath.sv
module ppg_datapath #(
  parameter int NUM_CH = ppg_pkg::NUM_CH,
  parameter int PERIOD = ppg_pkg::PERIOD,
  parameter int LEN_W  = ppg_pkg::LEN_W,
  parameter int CH_W   = $clog2(NUM_CH),
  parameter int PH_W   = $clog2(PERIOD)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  ppg_pkg::ppgStrobe_t            strobe,
  input  logic [PH_W-1:0]                phase,
  input  logic                           wrEn,
  input  logic [CH_W-1:0]                wrChan,
  input  logic [LEN_W-1:0]               wrLen,
  output logic [NUM_CH-1:0]              pulseOut,
  output logic [NUM_CH-1:0][LEN_W-1:0]   activeLen
);
  localparam int CMP_W   = PH_W + LEN_W;
  localparam int MAX_LEN = PERIOD - 1;

  logic [LEN_W-1:0] wrClamped;
  assign wrClamped = ppg_pkg::clampLen(wrLen, MAX_LEN);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    localparam logic [LEN_W-1:0] RST_LEN = ppg_pkg::defaultLen(i);
    logic [LEN_W-1:0] pendLen;
    logic             hit;

    assign hit = wrEn && (wrChan == CH_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        pendLen      <= RST_LEN;
        activeLen[i] <= RST_LEN;
      end else begin
        if (hit) pendLen <= wrClamped;
        if (strobe.wrap) activeLen[i] <= hit ? wrClamped : pendLen;
      end
    end

    assign pulseOut[i] = strobe.run &&
      (CMP_W'(phase) < CMP_W'(activeLen[i]));
  end
endmodule

// File: rtl/pulse_pattern_gen.sv
module pulse_pattern_gen #(
  parameter int NUM_CH = ppg_pkg::NUM_CH,
  parameter int PERIOD = ppg_pkg::PERIOD,
  parameter int LEN_W  = ppg_pkg::LEN_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      wrEn,
  input  logic [$clog2(NUM_CH)-1:0] wrChan,
  input  logic [LEN_W-1:0]          wrLen,
  output logic [NUM_CH-1:0]         pulseOut
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam int PH_W = $clog2(PERIOD);

  logic [PH_W-1:0]               phase;
  ppg_pkg::ppgStrobe_t           strobe;
  logic [NUM_CH-1:0][LEN_W-1:0]  activeLen;

  ppg_ctrl #(.PERIOD(PERIOD), .PH_W(PH_W)) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .phase(phase), .strobe(strobe)
  );

  ppg_datapath #(
    .NUM_CH(NUM_CH), .PERIOD(PERIOD), .LEN_W(LEN_W), .CH_W(CH_W), .PH_W(PH_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .phase(phase),
    .wrEn(wrEn), .wrChan(wrChan), .wrLen(wrLen),
    .pulseOut(pulseOut), .activeLen(activeLen)
  );
endmodule

// File: rtl/ppg_checker.sv
module ppg_checker #(
  parameter int NUM_CH = 12,
  parameter int PERIOD = 11,
  parameter int LEN_W  = 4,
  parameter int PH_W   = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          en,
  input logic [PH_W-1:0]               phase,
  input logic [NUM_CH-1:0][LEN_W-1:0]  activeLen,
  input logic [NUM_CH-1:0]             pulseOut
);
  logic isWrap;
  assign isWrap = en && (phase == PH_W'(PERIOD - 1));

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(phase) < PERIOD);                                            // R1
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && !isWrap) |=> phase == PH_W'($past(phase) + PH_W'(1)));    // R1
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    isWrap |=> phase == '0);                                          // R1
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |-> pulseOut == '0);                                          // R4
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(phase));                                          // R5
  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !isWrap |=> $stable(activeLen));                                  // R6

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_LEN_LIMITS: assert property (@(posedge clk) disable iff (rst)
      activeLen[i] != '0 && int'(activeLen[i]) < PERIOD);             // R7
  end
endmodule

bind pulse_pattern_gen ppg_checker #(
  .NUM_CH(NUM_CH), .PERIOD(PERIOD), .LEN_W(LEN_W), .PH_W(PH_W)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .phase(phase),
  .activeLen(activeLen), .pulseOut(pulseOut)
);

// File: tb/pulse_pattern_gen_tb.sv
module pulse_pattern_gen_tb;
  localparam int NCH = 12;
  localparam int PER = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrChan = '0;
  logic [3:0]  wrLen = '0;
  logic [NCH-1:0] pulseOut;

  int nChecks = 0;
  int nFails  = 0;

  // reference state built from the requirements
  int mPhase;
  int mAct [NCH];
  int mPend[NCH];
  int defLen[NCH] = '{8, 3, 7, 4, 6, 5, 9, 4, 7, 2, 6, 5};

  always #10 clk = ~clk;  // 50 MHz

  pulse_pattern_gen u_dut (
    .clk(clk), .rst(rst), .en(en), .wrEn(wrEn),
    .wrChan(wrChan), .wrLen(wrLen), .pulseOut(pulseOut)
  );

  function automatic int clampRef(input int v);
    if (v < 1) return 1;
    if (v > 10) return 10;
    return v;
  endfunction

  function automatic logic [NCH-1:0] expOut();
    logic [NCH-1:0] e;
    for (int i = 0; i < NCH; i++) e[i] = en && (mPhase < mAct[i]);
    return e;
  endfunction

  task automatic check(input logic [NCH-1:0] act, input logic [NCH-1:0] exp,
                       input string req);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: pulseOut=%h expected=%h (phase %0d)", req, act, exp, mPhase);
    end
  endtask

  // one clock: model follows inputs at the edge, outputs are compared at the falling edge
  task automatic step(input string req);
    @(posedge clk);
    if (rst) begin
      mPhase = 0;
      for (int i = 0; i < NCH; i++) begin mAct[i] = defLen[i]; mPend[i] = defLen[i]; end
    end else begin
      logic wrapNow;
      wrapNow = en && (mPhase == PER - 1);
      if (wrEn && wrChan < NCH) mPend[wrChan] = clampRef(int'(wrLen));
      if (wrapNow) for (int i = 0; i < NCH; i++) mAct[i] = mPend[i];
      if (en) mPhase = (mPhase + 1) % PER;
    end
    @(negedge clk);
    check(pulseOut, expOut(), req);
    wrEn = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1; en = 1'b1;
    step("R10");
    rst = 1'b0;
  endtask

  task automatic writeLen(input int ch, input int len, input string req);
    wrEn = 1'b1; wrChan = 4'(ch); wrLen = 4'(len);
    step(req);
  endtask

  task automatic runTo(input int ph, input string req);
    while (mPhase != ph) step(req);
  endtask

  // R3: reset state and first enabled cycle
  task automatic testReset();
    rst = 1'b1; en = 1'b0;
    step("R4");
    check(pulseOut, '0, "R4");
    en = 1'b1;
    step("R3");
    check(pulseOut, {NCH{1'b1}}, "R3");
    rst = 1'b0;
  endtask

  // R1/R2/R3: measure every run over 22 periods of the default pattern
  task automatic testRunLengths();
    int runLen[NCH];
    logic prevVal[NCH];
    int periodSeen = -1;
    doReset();
    for (int i = 0; i < NCH; i++) begin runLen[i] = 1; prevVal[i] = pulseOut[i]; end
    for (int c = 1; c < 22 * PER; c++) begin
      step("R2");
      if (pulseOut == {NCH{1'b1}} && c >= PER && periodSeen < 0) periodSeen = c;
      for (int i = 0; i < NCH; i++) begin
        if (pulseOut[i] == prevVal[i]) runLen[i]++;
        else begin
          int exp;
          exp = prevVal[i] ? defLen[i] : PER - defLen[i];
          nChecks++;
          if (runLen[i] != exp) begin
            nFails++;
            $display("FAIL R2 ch%0d: run=%0d expected=%0d (level %0b)", i, runLen[i], exp, prevVal[i]);
          end
          prevVal[i] = pulseOut[i];
          runLen[i] = 1;
        end
      end
    end
    nChecks++;
    if (periodSeen != PER) begin
      nFails++;
      $display("FAIL R1: all-high repeat at cycle %0d expected %0d", periodSeen, PER);
    end
  endtask

  // R4/R5: freeze and resume
  task automatic testEnable();
    doReset();
    en = 1'b1;
    runTo(5, "R5");
    en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      step("R4");
      check(pulseOut, '0, "R4");
    end
    en = 1'b1;
    step("R5");
    // frozen at 5, one step after resume gives phase 6: channels with length > 6 high
    check(pulseOut, 12'b0001_0100_0101, "R5");
    for (int k = 0; k < PER; k++) step("R5");
  endtask

  // R6: mid-period write is deferred to the wrap
  task automatic testDeferred();
    doReset();
    en = 1'b1;
    runTo(2, "R6");
    writeLen(9, 8, "R6");      // ch9 was 2: at phase 3 still low
    check(pulseOut[9], 1'b0, "R6");
    runTo(0, "R6");
    check(pulseOut[9], 1'b1, "R6");
    runTo(7, "R6");
    check(pulseOut[9], 1'b1, "R6");
    step("R6");
    check(pulseOut[9], 1'b0, "R6");
  endtask

  // R7: clamping of 0 and of values above 10
  task automatic testClamp();
    doReset();
    en = 1'b1;
    writeLen(0, 0, "R7");
    writeLen(1, 15, "R7");
    writeLen(2, 11, "R7");
    runTo(0, "R7");
    check(pulseOut[2:0], 3'b111, "R7");
    step("R7");                 // phase 1
    check(pulseOut[2:0], 3'b110, "R7");
    runTo(10, "R7");
    check(pulseOut[2:0], 3'b000, "R7");
    runTo(9, "R7");
    check(pulseOut[2:0], 3'b110, "R7");
  endtask

  // R8: write in the wrap cycle lands in the next period
  task automatic testWrapCollision();
    doReset();
    en = 1'b1;
    runTo(10, "R8");
    writeLen(6, 1, "R8");       // ch6 was 9
    check(pulseOut[6], 1'b1, "R8");
    step("R8");                 // phase 1
    check(pulseOut[6], 1'b0, "R8");
    runTo(8, "R8");
    check(pulseOut[6], 1'b0, "R8");
  endtask

  // R9: out-of-range channel index has no effect
  task automatic testBadChannel();
    doReset();
    en = 1'b1;
    writeLen(12, 1, "R9");
    writeLen(15, 10, "R9");
    writeLen(13, 1, "R9");
    for (int k = 0; k < 2 * PER; k++) step("R9");
    runTo(0, "R9");
    for (int k = 0; k < PER; k++) begin
      int ph;
      logic [NCH-1:0] e;
      ph = mPhase;
      for (int i = 0; i < NCH; i++) e[i] = ph < defLen[i];
      check(pulseOut, e, "R9");
      step("R9");
    end
  endtask

  // R10: reset mid-run with a pending write discards both
  task automatic testMidReset();
    doReset();
    en = 1'b1;
    runTo(6, "R10");
    writeLen(3, 10, "R10");
    rst = 1'b1;
    step("R10");
    rst = 1'b0;
    check(pulseOut, {NCH{1'b1}}, "R10");
    runTo(4, "R10");
    check(pulseOut[3], 1'b0, "R10");
    runTo(0, "R10");
    runTo(5, "R10");
    check(pulseOut[3], 1'b0, "R10");
  endtask

  bit finished = 1'b0;

  initial begin
    @(negedge clk);
    testReset();
    testRunLengths();
    testEnable();
    testDeferred();
    testClamp();
    testWrapCollision();
    testBadChannel();
    testMidReset();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule